// File: doc/BRIEF.md
# Free-Running Timer With Compare Match

A memory-mapped general-purpose timer built around a free-running up-counter. Software starts and stops counting with a control bit, reads and rewrites the count directly, and schedules a one-off event by writing a compare value ahead of the current count. A separate input, passed through a synchronizer, snapshots the count into a capture register on its rising edge.

Three sticky event flags report compare match, counter wrap and capture. Each flag is cleared by writing a one to its bit. A per-flag enable mask decides which flags drive the single interrupt output. Register reads are combinational from the word address, and writes take effect on the next rising clock edge.

Top module: `gp_match_timer`

## Requirements
- R1: After reset the count, compare, capture, flags, enable mask and control register all read zero, and the interrupt output is low.
- R2: While control bit 0 (run) is 1 the count rises by one on every clock edge; while it is 0 the count holds.
- R3: A write to the count register (word address 10) loads the written value on that edge, overriding the increment, and reads of address 10 return the current count.
- R4: When control bit 6 (compare enable) is 1, status bit 0 (match) sets on the edge where counting steps the count onto the compare value (word address 14). With compare enable at 0, match never sets.
- R5: Status bit 1 (overflow) sets on the edge where counting wraps the count from all ones to zero.
- R6: A rising edge on the capture input passes through a two-stage synchronizer. On the second clock edge after the input is first sampled high, the capture register (word address 15) takes the count held at that time, and status bit 2 (capture) sets.
- R7: Writing the status register (word address 6) clears each flag whose data bit is 1 and leaves flags under a 0 bit unchanged. A flag whose event occurs on the same edge as its clear stays set.
- R8: The interrupt output is high exactly when some status bit is 1 and the same bit of the enable register (word address 7) is 1. Bit 0 is match, bit 1 is overflow and bit 2 is capture.
- R9: The identity register at word address 0 returns a fixed parameter value, and writes to it have no effect.
- R10: The control register (word address 9) keeps only bits 0 and 6. Unimplemented bits and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cap_in | input | 1 | Asynchronous capture request, rising edge active |
| irq | output | 1 | Interrupt, OR of enabled flags |

## Verification
The hardest situation to reach from the ports is a status clear that lands on the very edge where the same flag's event fires. Reaching it needs the count one step short of the compare value with counting just started, followed by a status write on the next edge. The bench arranges this with back-to-back single-cycle writes. First the count is preset to one below the compare value. Then run is enabled, and the clearing write is issued immediately afterwards. A sweep over every compare value of an 8-bit instance, with the preset distance varied per value, also checks the exact edge at which match appears, including across the wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;

  // word addresses; software decodes these, so they are fixed
  localparam logic [ADDR_W-1:0] A_IDENT  = 4'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'd6;
  localparam logic [ADDR_W-1:0] A_INTEN  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd9;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'd10;
  localparam logic [ADDR_W-1:0] A_MATCH  = 4'd14;
  localparam logic [ADDR_W-1:0] A_CAPT   = 4'd15;

  // control bits
  localparam int CTRL_RUN   = 0;
  localparam int CTRL_CMPEN = 6;

  // event / flag bit positions
  localparam int EVT_MATCH = 0;
  localparam int EVT_OVF   = 1;
  localparam int EVT_CAPT  = 2;
  localparam int NUM_EVT   = 3;

  typedef struct packed {
    logic capt;
    logic ovf;
    logic match;
  } tmr_evt_t;

  function automatic logic wr_hit(input logic we,
                                  input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] target);
    return we && (a == target);
  endfunction
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             cmp_en_i,
  input  logic             wr_cnt_i,
  input  logic             wr_cmp_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_evt_o,
  output logic             ovf_evt_o
);
  localparam int SUM_W = CNT_W + 1;

  // increment with carry out; carry marks the wrap
  function automatic logic [SUM_W-1:0] incr(input logic [CNT_W-1:0] v);
    return {1'b0, v} + SUM_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic [SUM_W-1:0] sum;
  logic             step;

  assign step        = run_i && !wr_cnt_i;
  assign sum         = incr(cnt_q);
  assign ovf_evt_o   = step && sum[CNT_W];
  assign match_evt_o = step && cmp_en_i && (sum[CNT_W-1:0] == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt_i) begin
      cnt_q <= wdata_i;
    end else if (run_i) begin
      cnt_q <= sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_cmp_i) begin
      cmp_q <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_cnt_i) |=> $stable(cnt_q));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !wr_cnt_i) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt_i |=> (cnt_q == $past(wdata_i)));
  p_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt_o && !wr_cmp_i) |=> (cnt_q == cmp_q));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_o |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] capt_o,
  output logic             rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       capt_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= cap_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], cap_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      capt_q <= '0;
    else if (rise_o) capt_q <= cnt_i;
  end

  assign capt_o = capt_q;

  p_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> (capt_q == $past(cnt_i)));
  p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_o |=> $stable(capt_q));
endmodule

// File: rtl/tmr_event_flags.sv
module tmr_event_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_data_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         irq_o
);
  logic [N-1:0] flag_q, en_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[i] <= 1'b0;
        else        flag_q[i] <= set_i[i] || (flag_q[i] && !(clr_wr_i && clr_mask_i[i]));
      end

      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> flag_q[i]);
      p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && clr_mask_i[i] && !set_i[i]) |=> !flag_q[i]);
      p_zero_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !clr_mask_i[i] && flag_q[i]) |=> flag_q[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (en_wr_i) en_q <= en_data_i;
  end

  assign flags_o = flag_q;
  assign en_o    = en_q;
  assign irq_o   = |(flag_q & en_q);

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o);
  p_irq_noflag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !irq_o);
endmodule

// File: rtl/gp_match_timer.sv
module gp_match_timer
  import tmr_pkg::*;
#(
  parameter int          CNT_W       = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] ID_VALUE    = 32'h0000_0A31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        cap_in,
  output logic        irq
);
  logic             run_q, cmp_en_q;
  logic             wr_ctrl, wr_cnt, wr_cmp, wr_stat, wr_en;
  logic [CNT_W-1:0] cnt, cmp, capt;
  logic             match_evt, ovf_evt, capt_evt;
  tmr_evt_t         evt;
  logic [NUM_EVT-1:0] flags, en;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_ctrl = wr_hit(bus_we, bus_addr, A_CTRL);
  assign wr_cnt  = wr_hit(bus_we, bus_addr, A_COUNT);
  assign wr_cmp  = wr_hit(bus_we, bus_addr, A_MATCH);
  assign wr_stat = wr_hit(bus_we, bus_addr, A_STATUS);
  assign wr_en   = wr_hit(bus_we, bus_addr, A_INTEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cmp_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q    <= bus_wdata[CTRL_RUN];
      cmp_en_q <= bus_wdata[CTRL_CMPEN];
    end
  end

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_q),
    .cmp_en_i    (cmp_en_q),
    .wr_cnt_i    (wr_cnt),
    .wr_cmp_i    (wr_cmp),
    .wdata_i     (bus_wdata[CNT_W-1:0]),
    .cnt_o       (cnt),
    .cmp_o       (cmp),
    .match_evt_o (match_evt),
    .ovf_evt_o   (ovf_evt)
  );

  tmr_capture_unit #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_capt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (cap_in),
    .cnt_i  (cnt),
    .capt_o (capt),
    .rise_o (capt_evt)
  );

  always_comb begin
    evt       = '0;
    evt.match = match_evt;
    evt.ovf   = ovf_evt;
    evt.capt  = capt_evt;
  end

  tmr_event_flags #(.N(NUM_EVT)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt),
    .clr_wr_i   (wr_stat),
    .clr_mask_i (bus_wdata[NUM_EVT-1:0]),
    .en_wr_i    (wr_en),
    .en_data_i  (bus_wdata[NUM_EVT-1:0]),
    .flags_o    (flags),
    .en_o       (en),
    .irq_o      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_IDENT:  bus_rdata = ID_VALUE;
      A_STATUS: bus_rdata = BUS_W'(flags);
      A_INTEN:  bus_rdata = BUS_W'(en);
      A_CTRL: begin
        bus_rdata[CTRL_RUN]   = run_q;
        bus_rdata[CTRL_CMPEN] = cmp_en_q;
      end
      A_COUNT:  bus_rdata = BUS_W'(cnt);
      A_MATCH:  bus_rdata = BUS_W'(cmp);
      A_CAPT:   bus_rdata = BUS_W'(capt);
      default:  bus_rdata = '0;
    endcase
  end

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> ($stable(run_q) && $stable(cmp_en_q)));
  p_nomatch_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en_q && !flags[EVT_MATCH]) |=> !(flags[EVT_MATCH] && !$past(match_evt)));
endmodule

// File: tb/gp_match_timer_bench.sv
module gp_match_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [31:0] IDV = 32'h0000_0A31;
  localparam logic [3:0] AI = 4'd0, AS = 4'd6, AE = 4'd7, AC = 4'd9,
                         AN = 4'd10, AM = 4'd14, AP = 4'd15;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, cap_in = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  gp_match_timer #(.CNT_W(W), .ID_VALUE(IDV)) u_gp_match_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_reg("R1 count", AN, 0);
    expect_reg("R1 compare", AM, 0);
    expect_reg("R1 capture", AP, 0);
    expect_reg("R1 status", AS, 0);
    expect_reg("R1 enable", AE, 0);
    expect_reg("R1 control", AC, 0);
    check("R1 irq", 32'(irq), 0);

    // R9 identity, R10 map
    expect_reg("R9 identity", AI, IDV);
    wr(AI, 32'hFFFF_FFFF);
    expect_reg("R9 identity after write", AI, IDV);
    expect_reg("R10 unmapped", 4'd3, 0);
    wr(AC, 32'hFFFF_FFBE);
    expect_reg("R10 control bits", AC, 0);
    wr(AC, 32'hFFFF_FFFF);
    expect_reg("R10 control keeps 0 and 6", AC, 32'h41);
    wr(AC, 0);

    // R3 load, R2 hold and run
    wr(AN, 32'h5A);
    expect_reg("R3 count load", AN, 32'h5A);
    repeat (5) @(negedge clk);
    expect_reg("R2 hold while stopped", AN, 32'h5A);
    wr(AC, 1);
    repeat (4) @(negedge clk);
    expect_reg("R2 counts per edge", AN, 32'h5E);
    wr(AC, 0);
    repeat (3) @(negedge clk);
    expect_reg("R2 stop", AN, 32'h5F);

    // R4 no match without compare enable
    wr(AS, 7);
    wr(AM, 32'h70);
    wr(AN, 32'h6E);
    wr(AC, 1);
    repeat (4) @(negedge clk);
    expect_reg("R4 passed compare", AN, 32'h72);
    rd(AS, v);
    check("R4 no match when disabled", 32'(v[0]), 0);
    wr(AC, 0);

    // R4 sweep over every compare value
    wr(AE, 1);
    for (int m = 0; m < 256; m++) begin
      int d;
      d = (m % 7) + 1;
      wr(AC, 32'h40);
      wr(AS, 7);
      wr(AM, 32'(m));
      wr(AN, 32'((m - d) & 8'hFF));
      wr(AC, 32'h41);
      for (int k = 0; k < d; k++) begin
        rd(AS, v);
        check("R4 match early", 32'(v[0]), 0);
        @(negedge clk);
      end
      expect_reg("R4 count at match", AN, 32'(m));
      rd(AS, v);
      check("R4 match flag", 32'(v[0]), 1);
      check("R8 irq on match", 32'(irq), 1);
    end
    wr(AC, 32'h40);
    wr(AS, 7);

    // R7 event on the same edge as its clear
    wr(AM, 32'h30);
    wr(AN, 32'h2F);
    wr(AC, 32'h41);
    wr(AS, 1);
    rd(AS, v);
    check("R7 set beats clear", 32'(v[0]), 1);
    wr(AC, 32'h40);

    // R5 overflow
    wr(AN, 32'hFE);
    wr(AC, 1);
    @(negedge clk);
    rd(AS, v);
    check("R5 no wrap at all ones", 32'(v[1]), 0);
    @(negedge clk);
    expect_reg("R5 wrapped count", AN, 0);
    rd(AS, v);
    check("R5 overflow flag", 32'(v[1]), 1);
    wr(AC, 0);
    expect_reg("R5 status match+ovf", AS, 3);

    // R6 capture while stopped
    wr(AN, 32'h44);
    cap_in = 1'b1;
    repeat (3) @(negedge clk);
    expect_reg("R6 capture stopped", AP, 32'h44);
    expect_reg("R6 capture flag", AS, 7);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);

    // R6 capture while running
    wr(AS, 4);
    wr(AN, 32'h90);
    wr(AC, 1);
    @(negedge clk);
    rd(AN, c0);
    cap_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    expect_reg("R6 capture running", AP, (c0 + 2) & 32'hFF);
    wr(AC, 0);
    cap_in = 1'b0;
    repeat (3) @(negedge clk);
    expect_reg("R6 flag running", AS, 7);

    // R7 write-one-to-clear
    wr(AS, 0);
    expect_reg("R7 zero write", AS, 7);
    wr(AS, 2);
    expect_reg("R7 clear ovf only", AS, 5);

    // R8 irq sweep over enable masks and flag sets
    for (int s = 0; s < 3; s++) begin
      logic [2:0] fl;
      rd(AS, v);
      fl = v[2:0];
      for (int e = 0; e < 8; e++) begin
        wr(AE, 32'(e));
        expect_reg("R8 enable readback", AE, 32'(e));
        check("R8 irq", 32'(irq), 32'(|(fl & 3'(e))));
      end
      if (s == 0) wr(AS, 1);
      else        wr(AS, 4);
    end
    expect_reg("R7 all cleared", AS, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule